// File: doc/BRIEF.md
# Nested-Loop Descriptor DMA Engine

This block copies data from a source region to a destination region on behalf of up to 32 channels. Each channel's setup sits in one entry of a small descriptor table inside the block. The setup holds the source and destination addresses, a signed step for each address, a unit size, an inner byte budget and an outer repetition count. Software fills the table through a field-select write port and starts channels with a one-cycle pulse on a per-channel start vector.

A single shared transfer engine takes the started channels one after another. Each data unit is a read on the memory master port followed by a write of the same data, and both addresses then advance by their signed steps. Units repeat until the inner byte budget is used up. That inner pass is one minor loop. It decrements the channel's repetition count and writes the advanced addresses and the new count back into the table. When the count reaches zero, the channel's done flag is set and stays set until it is cleared.

Several channels may be started in the same cycle. The engine always resumes the lowest-numbered started channel, one minor loop at a time. In practice, channels started together therefore finish in ascending channel order.

Top module: `nldma_engine`

## Requirements
- R1: After reset all done flags are 0, `mem_req` is low and `busy` is low.
- R2: Each data unit is a read (`mem_we`=0) at the current source address, followed by a write (`mem_we`=1) at the current destination address that carries the data returned by the read; `mem_size` carries the channel's size code; the write is not requested before the read is acknowledged.
- R3: After each read/write pair the source address advances by the signed 16-bit source step and the destination address by the signed 16-bit destination step (two's complement, sign-extended to 32 bits, wrapping).
- R4: A unit moves 1 << size-code bytes (code 0..3 gives 1, 2, 4 or 8 bytes). A minor loop repeats units until the bytes moved are greater than or equal to the minor byte count, so it always performs at least one unit.
- R5: At the end of each minor loop the repetition count is decremented and the advanced addresses are stored back, so a channel restarted later, after only its count is rewritten, continues from where it stopped.
- R6: When the repetition count reaches zero the channel's done bit is set; it stays set until a `done_clr` pulse on that bit; a start pulse to a channel whose done bit is set causes no memory traffic.
- R7: Starting a channel whose repetition count is 0 sets its done bit without any memory traffic.
- R8: Among started channels, the lowest-numbered one is always served next, one whole minor loop at a time; channels started in the same cycle complete in ascending channel order.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_we`, `mem_addr`, `mem_size` and `mem_wdata` hold their values.
- R10: A write with `cfg_we`=1 updates one field of descriptor `cfg_ch`, chosen by `cfg_sel`: 0 source address, 1 destination address, 2 source step (bits 15:0), 3 destination step (bits 15:0), 4 size code (bits 1:0), 5 minor byte count (bits 15:0), 6 repetition count (bits 9:0); code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_ch | input | 5 | Channel whose descriptor is written |
| cfg_sel | input | 3 | Field select code (see R10) |
| cfg_wdata | input | 32 | Field write value |
| start_req | input | 32 | One bit per channel, pulse to start |
| done_clr | input | 32 | One bit per channel, pulse to clear done |
| done | output | 32 | Sticky per-channel completion flags |
| busy | output | 1 | Engine active or any channel waiting |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the access |
| mem_size | output | 2 | Size code, bytes = 1 << code |
| mem_wdata | output | 64 | Write data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per access |
| mem_rdata | input | 64 | Read data, valid with a read acknowledge |

## Verification
The assertions assume that the memory side raises `mem_ack` only while `mem_req` is high, and that `mem_rdata` is valid in the acknowledge cycle of a read. They also assume that software does not rewrite the descriptor of a channel while the engine is working on it. The stimulus keeps to these rules: the bench responder acknowledges only pending requests, after 0 to 2 random wait cycles, and always drops the acknowledge for a cycle afterwards. All descriptor programming happens while the engine is idle, before the start pulse of each scenario.

// File: rtl/nldma_pkg.sv
package nldma_pkg;
  localparam int AW     = 32;
  localparam int OFF_W  = 16;
  localparam int NB_W   = 16;
  localparam int IT_W   = 10;
  localparam int FSEL_W = 3;

  typedef enum logic [FSEL_W-1:0] {
    F_SRC    = 3'd0,
    F_DST    = 3'd1,
    F_SSTEP  = 3'd2,
    F_DSTEP  = 3'd3,
    F_SIZE   = 3'd4,
    F_NBYTES = 3'd5,
    F_ITER   = 3'd6
  } fsel_e;

  typedef struct packed {
    logic [AW-1:0]    src;
    logic [AW-1:0]    dst;
    logic [OFF_W-1:0] sstep;
    logic [OFF_W-1:0] dstep;
    logic [1:0]       size;
    logic [NB_W-1:0]  nbytes;
    logic [IT_W-1:0]  iter;
  } desc_t;

  typedef enum logic [2:0] {
    X_IDLE = 3'd0,
    X_LOAD = 3'd1,
    X_RD   = 3'd2,
    X_WR   = 3'd3,
    X_WB   = 3'd4
  } xstate_e;

  // bytes carried by one unit of the given size code
  function automatic logic [NB_W:0] unit_bytes(input logic [1:0] code);
    return (NB_W+1)'(1) << code;
  endfunction

  // address plus a sign-extended step
  function automatic logic [AW-1:0] adv_addr(input logic [AW-1:0] a,
                                             input logic [OFF_W-1:0] step);
    return a + {{(AW-OFF_W){step[OFF_W-1]}}, step};
  endfunction
endpackage

// File: rtl/nldma_desc_mem.sv
module nldma_desc_mem
  import nldma_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [FSEL_W-1:0] cfg_sel,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              wb_en,
  input  logic [CH_W-1:0]   wb_ch,
  input  logic [AW-1:0]     wb_src,
  input  logic [AW-1:0]     wb_dst,
  input  logic [IT_W-1:0]   wb_iter,
  input  logic [CH_W-1:0]   rd_ch,
  output desc_t             rd_desc
);
  desc_t tbl [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) tbl[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (wb_en && wb_ch == CH_W'(i)) begin
          // engine write-back of the running state
          tbl[i].src  <= wb_src;
          tbl[i].dst  <= wb_dst;
          tbl[i].iter <= wb_iter;
        end else if (cfg_we && cfg_ch == CH_W'(i)) begin
          // R10 field-select write
          case (fsel_e'(cfg_sel))
            F_SRC:    tbl[i].src    <= cfg_wdata;
            F_DST:    tbl[i].dst    <= cfg_wdata;
            F_SSTEP:  tbl[i].sstep  <= cfg_wdata[OFF_W-1:0];
            F_DSTEP:  tbl[i].dstep  <= cfg_wdata[OFF_W-1:0];
            F_SIZE:   tbl[i].size   <= cfg_wdata[1:0];
            F_NBYTES: tbl[i].nbytes <= cfg_wdata[NB_W-1:0];
            F_ITER:   tbl[i].iter   <= cfg_wdata[IT_W-1:0];
            default:  ;
          endcase
        end
      end
    end
  end

  assign rd_desc = tbl[rd_ch];
endmodule

// File: rtl/nldma_sched.sv
module nldma_sched #(
  parameter int NCH  = 32,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  start_req,
  input  logic [NCH-1:0]  done_clr,
  input  logic            fin_valid,
  input  logic [CH_W-1:0] fin_ch,
  output logic            grant_valid,
  output logic [CH_W-1:0] grant_ch,
  output logic [NCH-1:0]  pending,
  output logic [NCH-1:0]  done
);
  logic [NCH-1:0] fin_mask;

  assign fin_mask = fin_valid ? (NCH'(1) << fin_ch) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= '0;
      done    <= '0;
    end else begin
      // R6: a start on a finished channel is dropped
      pending <= (pending | (start_req & ~done)) & ~fin_mask;
      done    <= (done & ~done_clr) | fin_mask;
    end
  end

  // R8: lowest pending channel wins
  always_comb begin
    grant_valid = 1'b0;
    grant_ch    = '0;
    for (int i = NCH-1; i >= 0; i--) begin
      if (pending[i]) begin
        grant_valid = 1'b1;
        grant_ch    = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/nldma_xfer.sv
module nldma_xfer
  import nldma_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int DATA_W = 64,
  parameter int CH_W   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_valid,
  input  logic [CH_W-1:0]   grant_ch,
  output logic [CH_W-1:0]   rd_ch,
  input  desc_t             rd_desc,
  output logic              wb_en,
  output logic [CH_W-1:0]   wb_ch,
  output logic [AW-1:0]     wb_src,
  output logic [AW-1:0]     wb_dst,
  output logic [IT_W-1:0]   wb_iter,
  output logic              fin_valid,
  output logic [CH_W-1:0]   fin_ch,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              idle,
  output logic              rd_ack,
  output logic              wr_ack
);
  xstate_e           st;
  logic [CH_W-1:0]   ch_q;
  logic [AW-1:0]     s_q, d_q;
  logic [OFF_W-1:0]  sstep_q, dstep_q;
  logic [1:0]        size_q;
  logic [NB_W-1:0]   nb_q;
  logic [IT_W-1:0]   it_q;
  logic [NB_W:0]     moved_q, moved_nxt;
  logic [DATA_W-1:0] data_q;
  logic              minor_last;

  assign moved_nxt  = moved_q + unit_bytes(size_q);
  assign minor_last = moved_nxt >= {1'b0, nb_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= X_IDLE;
      ch_q    <= '0;
      s_q     <= '0;
      d_q     <= '0;
      sstep_q <= '0;
      dstep_q <= '0;
      size_q  <= '0;
      nb_q    <= '0;
      it_q    <= '0;
      moved_q <= '0;
      data_q  <= '0;
    end else begin
      case (st)
        X_IDLE: if (grant_valid) begin
          ch_q <= grant_ch;
          st   <= X_LOAD;
        end
        X_LOAD: begin
          s_q     <= rd_desc.src;
          d_q     <= rd_desc.dst;
          sstep_q <= rd_desc.sstep;
          dstep_q <= rd_desc.dstep;
          size_q  <= rd_desc.size;
          nb_q    <= rd_desc.nbytes;
          it_q    <= rd_desc.iter;
          moved_q <= '0;
          st      <= (rd_desc.iter == '0) ? X_IDLE : X_RD;
        end
        X_RD: if (mem_ack) begin
          data_q <= mem_rdata;
          st     <= X_WR;
        end
        X_WR: if (mem_ack) begin
          s_q     <= adv_addr(s_q, sstep_q);
          d_q     <= adv_addr(d_q, dstep_q);
          moved_q <= moved_nxt;
          st      <= minor_last ? X_WB : X_RD;
        end
        X_WB:    st <= X_IDLE;
        default: st <= X_IDLE;
      endcase
    end
  end

  assign rd_ch     = ch_q;
  assign mem_req   = (st == X_RD) || (st == X_WR);
  assign mem_we    = (st == X_WR);
  assign mem_addr  = (st == X_WR) ? d_q : s_q;
  assign mem_size  = size_q;
  assign mem_wdata = data_q;

  assign wb_en   = (st == X_WB);
  assign wb_ch   = ch_q;
  assign wb_src  = s_q;
  assign wb_dst  = d_q;
  assign wb_iter = it_q - IT_W'(1);

  assign fin_valid = ((st == X_LOAD) && (rd_desc.iter == '0)) ||
                     ((st == X_WB) && (it_q == IT_W'(1)));
  assign fin_ch    = ch_q;

  assign idle   = (st == X_IDLE);
  assign rd_ack = (st == X_RD) && mem_ack;
  assign wr_ack = (st == X_WR) && mem_ack;
endmodule

// File: rtl/nldma_engine.sv
module nldma_engine
  import nldma_pkg::*;
#(
  parameter int NCH    = 32,
  parameter int DATA_W = 64,
  parameter int CH_W   = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CH_W-1:0]   cfg_ch,
  input  logic [2:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic [NCH-1:0]    start_req,
  input  logic [NCH-1:0]    done_clr,
  output logic [NCH-1:0]    done,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic            grant_valid;
  logic [CH_W-1:0] grant_ch;
  logic [NCH-1:0]  pending;
  logic [CH_W-1:0] rd_ch;
  desc_t           rd_desc;
  logic            wb_en;
  logic [CH_W-1:0] wb_ch;
  logic [AW-1:0]   wb_src, wb_dst;
  logic [IT_W-1:0] wb_iter;
  logic            fin_valid;
  logic [CH_W-1:0] fin_ch;
  logic            idle, rd_ack, wr_ack;

  nldma_desc_mem #(.NCH(NCH), .CH_W(CH_W)) mem_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .wb_en(wb_en), .wb_ch(wb_ch), .wb_src(wb_src), .wb_dst(wb_dst),
    .wb_iter(wb_iter), .rd_ch(rd_ch), .rd_desc(rd_desc)
  );

  nldma_sched #(.NCH(NCH), .CH_W(CH_W)) sched_i (
    .clk(clk), .rst_n(rst_n),
    .start_req(start_req), .done_clr(done_clr),
    .fin_valid(fin_valid), .fin_ch(fin_ch),
    .grant_valid(grant_valid), .grant_ch(grant_ch),
    .pending(pending), .done(done)
  );

  nldma_xfer #(.NCH(NCH), .DATA_W(DATA_W), .CH_W(CH_W)) xfer_i (
    .clk(clk), .rst_n(rst_n),
    .grant_valid(grant_valid), .grant_ch(grant_ch),
    .rd_ch(rd_ch), .rd_desc(rd_desc),
    .wb_en(wb_en), .wb_ch(wb_ch), .wb_src(wb_src), .wb_dst(wb_dst),
    .wb_iter(wb_iter), .fin_valid(fin_valid), .fin_ch(fin_ch),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .idle(idle), .rd_ack(rd_ack), .wr_ack(wr_ack)
  );

  assign busy = !idle || (|pending);
endmodule

// File: rtl/nldma_checker.sv
module nldma_checker #(
  parameter int NCH    = 32,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_we,
  input logic [31:0]       mem_addr,
  input logic [1:0]        mem_size,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack,
  input logic [DATA_W-1:0] mem_rdata,
  input logic [NCH-1:0]    done,
  input logic [NCH-1:0]    done_clr,
  input logic              fin_valid,
  input logic              rd_ack,
  input logic              wr_ack,
  input logic              wb_en,
  input logic              idle
);
  a_r9_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                            && $stable(mem_size) && $stable(mem_wdata));

  a_r2_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |=> mem_req && mem_we && (mem_wdata == $past(mem_rdata)));

  a_r2_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(rd_ack));

  a_r5_writeback_after_unit: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(wr_ack));

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(done) & ~$past(done_clr) & ~done) == '0));

  a_r6_done_rise_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~$past(done)) != '0) |-> $past(fin_valid));

  a_r1_no_req_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !mem_req);
endmodule

bind nldma_engine nldma_checker #(.NCH(NCH), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_size(mem_size), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .mem_rdata(mem_rdata),
  .done(done), .done_clr(done_clr),
  .fin_valid(fin_valid), .rd_ack(rd_ack), .wr_ack(wr_ack),
  .wb_en(wb_en), .idle(idle)
);

// File: tb/nldma_engine_tb_top.sv
module nldma_engine_tb_top;
  localparam int NCH  = 32;
  localparam int DW   = 64;
  localparam int LOGN = 4096;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [4:0]      cfg_ch = '0;
  logic [2:0]      cfg_sel = '0;
  logic [31:0]     cfg_wdata = '0;
  logic [NCH-1:0]  start_req = '0;
  logic [NCH-1:0]  done_clr = '0;
  logic [NCH-1:0]  done;
  logic            busy;
  logic            mem_req, mem_we;
  logic [31:0]     mem_addr;
  logic [1:0]      mem_size;
  logic [DW-1:0]   mem_wdata;
  logic            mem_ack = 1'b0;
  logic [DW-1:0]   mem_rdata = '0;

  always #10 clk = ~clk;

  nldma_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .start_req(start_req), .done_clr(done_clr), .done(done), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_size(mem_size), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int errors = 0;

  // observed accesses
  logic        log_we [LOGN];
  logic [31:0] log_addr [LOGN];
  logic [1:0]  log_size [LOGN];
  logic [63:0] log_data [LOGN];
  int          log_n = 0;
  // expected accesses
  logic        exp_we [LOGN];
  logic [31:0] exp_addr [LOGN];
  logic [1:0]  exp_size [LOGN];
  logic [63:0] exp_data [LOGN];
  int          exp_n = 0;

  // bench copy of what each descriptor should hold
  logic [31:0] sh_src [NCH];
  logic [31:0] sh_dst [NCH];
  logic [15:0] sh_ss [NCH];
  logic [15:0] sh_ds [NCH];
  logic [1:0]  sh_sz [NCH];
  logic [15:0] sh_nb [NCH];
  logic [9:0]  sh_it [NCH];

  function automatic logic [63:0] pat(input logic [31:0] a);
    return {~a, a ^ 32'h5A5A_0F0F};
  endfunction

  function automatic logic [31:0] step(input logic [31:0] a, input logic [15:0] o);
    return a + 32'($signed(o));
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // memory responder: 0..2 wait cycles, one-cycle ack, records accesses
  int          wait_cnt = 0;
  int          hold_err = 0;
  logic        prev_pend = 1'b0;
  logic [31:0] prev_addr = '0;
  logic        prev_we = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      prev_pend = 1'b0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      prev_pend = 1'b0;
    end else if (mem_req) begin
      if (prev_pend && (mem_addr !== prev_addr || mem_we !== prev_we)) hold_err++;
      prev_pend = 1'b1;
      prev_addr = mem_addr;
      prev_we   = mem_we;
      if (wait_cnt == 0) begin
        mem_ack = 1'b1;
        if (!mem_we) mem_rdata = pat(mem_addr);
        if (log_n < LOGN) begin
          log_we[log_n]   = mem_we;
          log_addr[log_n] = mem_addr;
          log_size[log_n] = mem_size;
          log_data[log_n] = mem_we ? mem_wdata : pat(mem_addr);
        end
        log_n++;
        wait_cnt = int'($urandom % 3);
      end else begin
        wait_cnt--;
      end
    end
  end

  task automatic push(input logic we, input logic [31:0] a, input logic [1:0] sz,
                      input logic [63:0] d);
    if (exp_n < LOGN) begin
      exp_we[exp_n] = we; exp_addr[exp_n] = a; exp_size[exp_n] = sz; exp_data[exp_n] = d;
    end
    exp_n++;
  endtask

  // expected traffic of a channel run to completion
  task automatic expect_ch(input int c);
    int moved;
    for (int it = 0; it < int'(sh_it[c]); it++) begin
      moved = 0;
      do begin
        push(1'b0, sh_src[c], sh_sz[c], pat(sh_src[c]));
        push(1'b1, sh_dst[c], sh_sz[c], pat(sh_src[c]));
        sh_src[c] = step(sh_src[c], sh_ss[c]);
        sh_dst[c] = step(sh_dst[c], sh_ds[c]);
        moved += (1 << sh_sz[c]);
      end while (moved < int'(sh_nb[c]));
    end
    sh_it[c] = '0;
  endtask

  task automatic compare_log(input string req);
    chk(log_n == exp_n, req, "access count", 64'(log_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < log_n && i < LOGN; i++) begin
      chk(log_we[i] == exp_we[i] && log_addr[i] == exp_addr[i] &&
          log_size[i] == exp_size[i] && log_data[i] == exp_data[i],
          req, $sformatf("access %0d we/size/addr", i),
          {29'(0), log_we[i], log_size[i], log_addr[i]},
          {29'(0), exp_we[i], exp_size[i], exp_addr[i]});
    end
    log_n = 0;
    exp_n = 0;
  endtask

  task automatic wr_field(input int c, input int sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 5'(c); cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R10 field codes: 0 src, 1 dst, 2 sstep, 3 dstep, 4 size, 5 bytes, 6 count
  task automatic prog(input int c, input logic [31:0] s, input logic [31:0] d,
                      input logic [15:0] ss, input logic [15:0] ds, input logic [1:0] sz,
                      input logic [15:0] nb, input logic [9:0] it);
    wr_field(c, 0, s);  wr_field(c, 1, d);
    wr_field(c, 2, {16'hFFFF, ss}); wr_field(c, 3, {16'h0, ds});
    wr_field(c, 4, {30'h3FFF_FFFF, sz}); wr_field(c, 5, {16'hABCD, nb});
    wr_field(c, 6, {22'h0, it});
    wr_field(c, 7, 32'hDEAD_BEEF);
    sh_src[c] = s; sh_dst[c] = d; sh_ss[c] = ss; sh_ds[c] = ds;
    sh_sz[c] = sz; sh_nb[c] = nb; sh_it[c] = it;
  endtask

  task automatic pulse_start(input logic [NCH-1:0] m);
    @(negedge clk); start_req = m;
    @(negedge clk); start_req = '0;
  endtask

  task automatic pulse_clr(input logic [NCH-1:0] m);
    @(negedge clk); done_clr = m;
    @(negedge clk); done_clr = '0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [NCH-1:0] exp_done;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done == '0, "R1", "done after reset", 64'(done), 64'h0);
    chk(mem_req == 1'b0, "R1", "mem_req after reset", 64'(mem_req), 64'h0);
    chk(busy == 1'b0, "R1", "busy after reset", 64'(busy), 64'h0);

    // R2 R3 R10: one channel, two minor loops of three 4-byte units
    prog(3, 32'h0000_1000, 32'h0000_2000, 16'd4, 16'd8, 2'd2, 16'd12, 10'd2);
    pulse_start(32'h8);
    wait_idle();
    expect_ch(3);
    compare_log("R2/R3");
    exp_done = 32'h8;
    chk(done == exp_done, "R6", "done after first run", 64'(done), 64'(exp_done));

    // R4: negative steps, byte count not a multiple, byte count zero
    prog(7, 32'h0000_8000, 32'h0000_9000, 16'hFFF8, 16'hFFFE, 2'd3, 16'd20, 10'd1);
    prog(8, 32'h0000_0003, 32'hFFFF_FFFF, 16'd1, 16'd1, 2'd0, 16'd0, 10'd3);
    pulse_start(32'h180);
    wait_idle();
    expect_ch(7);
    expect_ch(8);
    compare_log("R4");
    exp_done = exp_done | 32'h180;
    chk(done == exp_done, "R4", "done after step test", 64'(done), 64'(exp_done));

    // R6: start on a finished channel is ignored
    pulse_start(32'h8);
    repeat (20) @(negedge clk);
    chk(log_n == 0, "R6", "traffic after start on done channel", 64'(log_n), 64'h0);
    chk(done == exp_done, "R6", "done kept", 64'(done), 64'(exp_done));
    log_n = 0;

    // R5: clear, rewrite only the count, restart continues from written-back addresses
    pulse_clr(32'h8);
    exp_done = exp_done & ~32'h8;
    chk(done == exp_done, "R6", "done after clear", 64'(done), 64'(exp_done));
    wr_field(3, 6, 32'd1);
    sh_it[3] = 10'd1;
    pulse_start(32'h8);
    wait_idle();
    expect_ch(3);
    compare_log("R5");
    exp_done = exp_done | 32'h8;
    chk(done == exp_done, "R5", "done after restart", 64'(done), 64'(exp_done));

    // R7: zero count finishes with no traffic
    prog(10, 32'h100, 32'h200, 16'd1, 16'd1, 2'd0, 16'd4, 10'd0);
    pulse_start(32'h400);
    wait_idle();
    chk(log_n == 0, "R7", "traffic for zero count", 64'(log_n), 64'h0);
    exp_done = exp_done | 32'h400;
    chk(done == exp_done, "R7", "done for zero count", 64'(done), 64'(exp_done));
    log_n = 0;

    // R8: three channels started together finish in ascending order
    pulse_clr('1);
    prog(20, 32'h4000, 32'h5000, 16'd2, 16'd2, 2'd1, 16'd4, 10'd2);
    prog(12, 32'h6000, 32'h7000, 16'd1, 16'hFFFF, 2'd0, 16'd3, 10'd2);
    prog(31, 32'hA000, 32'hB000, 16'd8, 16'd16, 2'd3, 16'd16, 10'd1);
    pulse_start(32'h8010_1000);
    wait_idle();
    expect_ch(12);
    expect_ch(20);
    expect_ch(31);
    compare_log("R8");
    chk(done == 32'h8010_1000, "R8", "done mask", 64'(done), 64'h8010_1000);

    // R8 constrained random rounds
    for (int r = 0; r < 8; r++) begin
      logic [NCH-1:0] m;
      pulse_clr('1);
      m = NCH'($urandom & $urandom & $urandom);
      if (m == '0) m = NCH'(1) << ($urandom % NCH);
      for (int c = 0; c < NCH; c++) begin
        if (m[c])
          prog(c, $urandom, $urandom, 16'($urandom % 64) - 16'd32,
               16'($urandom % 64) - 16'd32, 2'($urandom % 4),
               16'($urandom % 40), 10'($urandom % 4));
      end
      pulse_start(m);
      wait_idle();
      for (int c = 0; c < NCH; c++) if (m[c]) expect_ch(c);
      compare_log("R8 random");
      chk(done == m, "R8", "random done mask", 64'(done), 64'(m));
    end

    // R9 request held until acknowledged
    chk(hold_err == 0, "R9", "request changed before ack", 64'(hold_err), 64'h0);

    summary();
    $finish;
  end
endmodule